// File: doc/BRIEF.md
# Bank-Balancing Prefetch Issue Arbiter

This block sits between a hardware prefetcher and the miss-tracking registers (MSHRs) of one core. Candidate prefetches arrive tagged with the DRAM bank they map to. Each one waits in a small queue that belongs to its bank. Every cycle the arbiter offers one queue head on a valid/ready output. It picks the bank that currently has the fewest outstanding misses, so that prefetches spread across banks rather than piling onto one. The result is more bank-level parallelism in the memory system.

The arbiter keeps one outstanding-miss counter per bank. The counters are driven by allocate and free events that the MSHR logic reports, each tagged with a bank, and they cover both demand and prefetch misses. A bank stops taking prefetches once its counter rises above a send limit. That limit is recomputed at the end of every fixed interval from the issued and useful prefetch counts supplied for that interval. Inaccurate prefetching therefore shrinks the share of MSHRs that prefetches may reserve. Nothing is issued while the MSHRs are full.

Top module: `pf_bank_arb`

## Requirements
- R1: Each bank has its own first-in first-out queue of depth FIFO_DEPTH (default 4). A pushed prefetch joins the queue selected by `pf_push_bank`. Within one bank, addresses leave in the order they were accepted.
- R2: `pf_push_ready` is low exactly when the queue of the bank on `pf_push_bank` is full. A push offered while it is low is dropped and never issued. Pushes to other banks are still accepted.
- R3: A bank's outstanding-miss count rises by one after a cycle with an allocate event for that bank, and falls by one after a free event for that bank. When both events hit the same bank in one cycle, the count stays unchanged. Each change is visible from the next cycle on.
- R4: A non-empty bank queue may issue only while that bank's count is less than or equal to the current send limit. A count equal to the limit is still eligible.
- R5: Among the eligible banks, `iss_bank`/`iss_addr` show the head of the bank with the smallest count. A tie goes to the lowest bank index. `iss_valid` is high whenever at least one bank is eligible.
- R6: A queue head is removed only in a cycle where `iss_valid` and `iss_ready` are both high. While `iss_ready` stays low, the offered request stays the same unless the counts change. After reset, `iss_valid` is low and `pf_push_ready` is high.
- R7: While the counts of all banks together reach MSHR_ENTRIES (default 32), `iss_valid` stays low, even for eligible queues.
- R8: At the last cycle of every interval of INTERVAL cycles, with I = `acc_issued` and U = `acc_useful` both nonzero-issued, the limit becomes 1 if 100·U < 40·I, 7 if 40·I ≤ 100·U < 85·I, and 27 otherwise.
- R9: When `acc_issued` is zero at the end of an interval, the limit keeps its previous value. The limit changes at no other time. It is 7 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_push_valid | input | 1 | Prefetcher offers a request |
| pf_push_ready | output | 1 | Target bank queue has room |
| pf_push_bank | input | BANK_W | Bank the offered request maps to |
| pf_push_addr | input | ADDR_W | Address of the offered request |
| mshr_alloc_valid | input | 1 | An MSHR entry was allocated |
| mshr_alloc_bank | input | BANK_W | Bank of the allocated entry |
| mshr_free_valid | input | 1 | An MSHR entry was released |
| mshr_free_bank | input | BANK_W | Bank of the released entry |
| acc_issued | input | CNT_W | Prefetches issued in the current interval |
| acc_useful | input | CNT_W | Prefetches found useful in the current interval |
| iss_valid | output | 1 | A prefetch is offered to the MSHRs |
| iss_ready | input | 1 | MSHR side accepts the offered prefetch |
| iss_bank | output | BANK_W | Bank of the offered prefetch |
| iss_addr | output | ADDR_W | Address of the offered prefetch |

## Verification
On every cycle, the embedded assertions check several things. An offered request's bank is within the send limit and has no eligible bank below it in count (R4, R5). Nothing is offered while the MSHRs are full (R7). Queues are never pushed when full or popped when empty (R2, R6). A same-cycle allocate and free leaves a count untouched (R3). The limit holds one of its three values and moves only at an interval end (R8, R9). Only the bench's scenarios can show the other behaviours: the accuracy-to-limit mapping at its exact 40% and 85% edges, the kept value when nothing was issued, the order addresses leave a queue, the drain order across banks with tied counts, and the release of issue once a full MSHR pool frees an entry. The bench observes the limit only through which queue heads become eligible.

// File: rtl/pf_arb_pkg.sv
package pf_arb_pkg;

   typedef enum logic [1:0] {
      ACC_POOR = 2'd0,
      ACC_FAIR = 2'd1,
      ACC_GOOD = 2'd2
   } acc_band_e;

   // Place a usefulness ratio into a band using scaled products only.
   function automatic acc_band_e acc_band(input logic [63:0] useful_scaled,
                                          input logic [63:0] edge_lo,
                                          input logic [63:0] edge_hi);
      if (useful_scaled < edge_lo)      return ACC_POOR;
      else if (useful_scaled < edge_hi) return ACC_FAIR;
      else                              return ACC_GOOD;
   endfunction

endpackage

// File: rtl/pf_bank_fifo.sv
module pf_bank_fifo #(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] head_o,
   output logic              empty_o,
   output logic              full_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pf_bank_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  fill;

   assign empty_o = (fill == '0);
   assign full_o  = (fill == CNT_W'(DEPTH));
   assign head_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_i) mem[wr_ptr] <= data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push_i) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop_i)  rd_ptr <= rd_ptr + PTR_W'(1);
         case ({push_i, pop_i})
            2'b10:   fill <= fill + CNT_W'(1);
            2'b01:   fill <= fill - CNT_W'(1);
            default: fill <= fill;
         endcase
      end
   end

   assert_no_overflow_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   assert_no_underflow_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

endmodule

// File: rtl/pf_occ_ctr.sv
module pf_occ_ctr #(
   parameter int OCC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             dec_i,
   output logic [OCC_W-1:0] occ_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_o <= '0;
      end else if (inc_i && !dec_i) begin
         occ_o <= occ_o + OCC_W'(1);
      end else if (dec_i && !inc_i) begin
         occ_o <= occ_o - OCC_W'(1);
      end
   end

   assert_hold_on_both_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && dec_i) |=> $stable(occ_o));

endmodule

// File: rtl/pf_limit_ctl.sv
module pf_limit_ctl
   import pf_arb_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int THR_W     = 6,
   parameter int INTERVAL  = 100000,
   parameter int PCT_LOW   = 40,
   parameter int PCT_HIGH  = 85,
   parameter int LIM_POOR  = 1,
   parameter int LIM_FAIR  = 7,
   parameter int LIM_GOOD  = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] issued_i,
   input  logic [CNT_W-1:0] useful_i,
   output logic [THR_W-1:0] limit_o,
   output logic             tick_o
);
   localparam int TMR_W = $clog2(INTERVAL);

   if (INTERVAL < 2) begin : g_bad_interval
      $error("pf_limit_ctl: INTERVAL must be at least 2");
   end
   if (!(PCT_LOW < PCT_HIGH && PCT_HIGH <= 100)) begin : g_bad_pct
      $error("pf_limit_ctl: accuracy edges must rise and stay within 100");
   end

   logic [TMR_W-1:0] tmr;
   logic [63:0]      u_scaled, e_lo, e_hi;
   acc_band_e        band;
   logic [THR_W-1:0] next_limit;

   assign tick_o = (tmr == TMR_W'(INTERVAL - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      tmr <= '0;
      else if (tick_o) tmr <= '0;
      else             tmr <= tmr + TMR_W'(1);
   end

   always_comb begin
      u_scaled = 64'(useful_i) * 64'(100);
      e_lo     = 64'(issued_i) * 64'(PCT_LOW);
      e_hi     = 64'(issued_i) * 64'(PCT_HIGH);
      band     = acc_band(u_scaled, e_lo, e_hi);
      case (band)
         ACC_POOR: next_limit = THR_W'(LIM_POOR);
         ACC_FAIR: next_limit = THR_W'(LIM_FAIR);
         default:  next_limit = THR_W'(LIM_GOOD);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                          limit_o <= THR_W'(LIM_FAIR);
      else if (tick_o && issued_i != '0)   limit_o <= next_limit;
   end

   assert_limit_legal_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (limit_o == THR_W'(LIM_POOR)) || (limit_o == THR_W'(LIM_FAIR)) ||
      (limit_o == THR_W'(LIM_GOOD)));
   assert_limit_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_o || issued_i == '0) |=> $stable(limit_o));

endmodule

// File: rtl/pf_min_pick.sv
module pf_min_pick #(
   parameter int NB = 4,
   parameter int VW = 6,
   parameter int BW = 2
) (
   input  logic [NB-1:0] cand_i,
   input  logic [VW-1:0] val_i [NB],
   output logic          found_o,
   output logic [BW-1:0] sel_o
);
   logic [VW-1:0] best;

   // Strict less-than keeps the lowest index among equal minima.
   always_comb begin
      found_o = 1'b0;
      sel_o   = '0;
      best    = '0;
      for (int b = 0; b < NB; b++) begin
         if (cand_i[b] && (!found_o || val_i[b] < best)) begin
            found_o = 1'b1;
            sel_o   = BW'(b);
            best    = val_i[b];
         end
      end
   end

endmodule

// File: rtl/pf_bank_arb.sv
module pf_bank_arb #(
   parameter int NUM_BANKS    = 4,
   parameter int FIFO_DEPTH   = 4,
   parameter int ADDR_W       = 32,
   parameter int MSHR_ENTRIES = 32,
   parameter int CNT_W        = 16,
   parameter int INTERVAL     = 100000,
   parameter int PCT_LOW      = 40,
   parameter int PCT_HIGH     = 85,
   parameter int LIM_POOR     = 1,
   parameter int LIM_FAIR     = 7,
   parameter int LIM_GOOD     = 27,
   localparam int BANK_W      = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pf_push_valid,
   output logic              pf_push_ready,
   input  logic [BANK_W-1:0] pf_push_bank,
   input  logic [ADDR_W-1:0] pf_push_addr,
   input  logic              mshr_alloc_valid,
   input  logic [BANK_W-1:0] mshr_alloc_bank,
   input  logic              mshr_free_valid,
   input  logic [BANK_W-1:0] mshr_free_bank,
   input  logic [CNT_W-1:0]  acc_issued,
   input  logic [CNT_W-1:0]  acc_useful,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic [BANK_W-1:0] iss_bank,
   output logic [ADDR_W-1:0] iss_addr
);
   localparam int OCC_W = $clog2(MSHR_ENTRIES + 1);
   localparam int TOT_W = OCC_W + BANK_W;

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("pf_bank_arb: NUM_BANKS must be a power of two of at least 2");
   end
   if (!(LIM_POOR <= LIM_FAIR && LIM_FAIR <= LIM_GOOD && LIM_GOOD <= MSHR_ENTRIES)) begin : g_bad_lim
      $error("pf_bank_arb: send limits must rise and fit the MSHR count");
   end

   logic [NUM_BANKS-1:0] q_push, q_pop, q_empty, q_full, elig;
   logic [ADDR_W-1:0]    q_head [NUM_BANKS];
   logic [OCC_W-1:0]     occ    [NUM_BANKS];
   logic [OCC_W-1:0]     limit;
   logic                 tick;
   logic [TOT_W-1:0]     total;
   logic                 mshr_full;
   logic                 any_elig;
   logic [BANK_W-1:0]    pick;

   assign pf_push_ready = !q_full[pf_push_bank];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign q_push[b] = pf_push_valid && (pf_push_bank == BANK_W'(b)) && !q_full[b];
      assign q_pop[b]  = iss_valid && iss_ready && (pick == BANK_W'(b));
      assign elig[b]   = !q_empty[b] && (occ[b] <= limit) && !mshr_full;

      pf_bank_fifo #(
         .DEPTH  (FIFO_DEPTH),
         .DATA_W (ADDR_W)
      ) u_fifo (
         .clk     (clk),
         .rst_n   (rst_n),
         .push_i  (q_push[b]),
         .data_i  (pf_push_addr),
         .pop_i   (q_pop[b]),
         .head_o  (q_head[b]),
         .empty_o (q_empty[b]),
         .full_o  (q_full[b])
      );

      pf_occ_ctr #(
         .OCC_W (OCC_W)
      ) u_occ (
         .clk   (clk),
         .rst_n (rst_n),
         .inc_i (mshr_alloc_valid && (mshr_alloc_bank == BANK_W'(b))),
         .dec_i (mshr_free_valid && (mshr_free_bank == BANK_W'(b))),
         .occ_o (occ[b])
      );

      assert_min_pick_R5 : assert property (@(posedge clk) disable iff (!rst_n)
         (iss_valid && !q_empty[b] && occ[b] <= limit) |-> (occ[iss_bank] <= occ[b]));
   end

   always_comb begin
      total = '0;
      for (int b = 0; b < NUM_BANKS; b++) total = total + TOT_W'(occ[b]);
   end
   assign mshr_full = (total >= TOT_W'(MSHR_ENTRIES));

   pf_limit_ctl #(
      .CNT_W    (CNT_W),
      .THR_W    (OCC_W),
      .INTERVAL (INTERVAL),
      .PCT_LOW  (PCT_LOW),
      .PCT_HIGH (PCT_HIGH),
      .LIM_POOR (LIM_POOR),
      .LIM_FAIR (LIM_FAIR),
      .LIM_GOOD (LIM_GOOD)
   ) u_limit (
      .clk      (clk),
      .rst_n    (rst_n),
      .issued_i (acc_issued),
      .useful_i (acc_useful),
      .limit_o  (limit),
      .tick_o   (tick)
   );

   pf_min_pick #(
      .NB (NUM_BANKS),
      .VW (OCC_W),
      .BW (BANK_W)
   ) u_pick (
      .cand_i  (elig),
      .val_i   (occ),
      .found_o (any_elig),
      .sel_o   (pick)
   );

   assign iss_valid = any_elig;
   assign iss_bank  = pick;
   assign iss_addr  = q_head[pick];

   assert_within_limit_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (occ[iss_bank] <= limit));
   assert_full_blocks_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (total >= TOT_W'(MSHR_ENTRIES)) |-> !iss_valid);
   assert_limit_at_tick_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(limit));

endmodule

// File: tb/pf_bank_arb_test.sv
module pf_bank_arb_test;
   localparam int CLK_PERIOD = 10;
   localparam int INTERVAL   = 16;
   localparam int BANK_W     = 2;
   localparam int ADDR_W     = 32;
   localparam int CNT_W      = 16;
   localparam int NVEC       = 9;
   // {issued, useful, expected limit}
   localparam logic [39:0] VEC [NVEC] = '{
      {16'd100, 16'd39, 8'd1},  {16'd100, 16'd40, 8'd7},
      {16'd100, 16'd84, 8'd7},  {16'd100, 16'd85, 8'd27},
      {16'd0,   16'd0,  8'd27}, {16'd200, 16'd79, 8'd1},
      {16'd0,   16'd5,  8'd1},  {16'd20,  16'd20, 8'd27},
      {16'd7,   16'd3,  8'd7}
   };

   logic clk = 0, rst_n = 0;
   logic pf_push_valid = 0, pf_push_ready;
   logic [BANK_W-1:0] pf_push_bank = '0;
   logic [ADDR_W-1:0] pf_push_addr = '0;
   logic mshr_alloc_valid = 0, mshr_free_valid = 0;
   logic [BANK_W-1:0] mshr_alloc_bank = '0, mshr_free_bank = '0;
   logic [CNT_W-1:0] acc_issued = '0, acc_useful = '0;
   logic iss_valid, iss_ready = 0;
   logic [BANK_W-1:0] iss_bank;
   logic [ADDR_W-1:0] iss_addr;
   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pf_bank_arb #(.INTERVAL(INTERVAL)) uut (
      .clk(clk), .rst_n(rst_n),
      .pf_push_valid(pf_push_valid), .pf_push_ready(pf_push_ready),
      .pf_push_bank(pf_push_bank), .pf_push_addr(pf_push_addr),
      .mshr_alloc_valid(mshr_alloc_valid), .mshr_alloc_bank(mshr_alloc_bank),
      .mshr_free_valid(mshr_free_valid), .mshr_free_bank(mshr_free_bank),
      .acc_issued(acc_issued), .acc_useful(acc_useful),
      .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_bank(iss_bank), .iss_addr(iss_addr));

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push(input int bank, input int addr, output bit rdy);
      pf_push_valid = 1; pf_push_bank = BANK_W'(bank); pf_push_addr = ADDR_W'(addr);
      #1 rdy = pf_push_ready;
      @(negedge clk);
      pf_push_valid = 0;
   endtask

   task automatic alloc(input int bank, input int n);
      for (int i = 0; i < n; i++) begin
         mshr_alloc_valid = 1; mshr_alloc_bank = BANK_W'(bank);
         @(negedge clk);
         mshr_alloc_valid = 0;
      end
   endtask

   task automatic release_n(input int bank, input int n);
      for (int i = 0; i < n; i++) begin
         mshr_free_valid = 1; mshr_free_bank = BANK_W'(bank);
         @(negedge clk);
         mshr_free_valid = 0;
      end
   endtask

   task automatic both(input int bank);
      mshr_alloc_valid = 1; mshr_alloc_bank = BANK_W'(bank);
      mshr_free_valid = 1;  mshr_free_bank = BANK_W'(bank);
      @(negedge clk);
      mshr_alloc_valid = 0; mshr_free_valid = 0;
   endtask

   task automatic pop_expect(input string req, input int bank, input int addr);
      iss_ready = 1;
      #1;
      check(req, "pop valid", iss_valid, 1);
      check(req, "pop bank", iss_bank, bank);
      check(req, "pop addr", iss_addr, addr);
      @(negedge clk);
      iss_ready = 0;
   endtask

   // Reveals the current limit through eligibility of a bank-0 head.
   task automatic probe_limit(output int lim);
      bit r, v2, v8;
      push(0, 'hA0, r);
      alloc(0, 2);
      v2 = iss_valid;
      alloc(0, 6);
      v8 = iss_valid;
      release_n(0, 8);
      pop_expect("R4", 0, 'hA0);
      lim = v8 ? 27 : (v2 ? 7 : 1);
   endtask

   task automatic set_acc(input int issued, input int useful);
      acc_issued = CNT_W'(issued); acc_useful = CNT_W'(useful);
      repeat (INTERVAL + 2) @(negedge clk);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int lim;
      bit r;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R6", "reset iss_valid", iss_valid, 0);
      check("R6", "reset push ready", pf_push_ready, 1);
      probe_limit(lim);
      check("R9", "reset limit", lim, 7);

      // Accuracy vectors, R8 bands and R9 hold on zero issued
      for (int i = 0; i < NVEC; i++) begin
         set_acc(int'(VEC[i][39:24]), int'(VEC[i][23:8]));
         probe_limit(lim);
         check(VEC[i][39:24] == 0 ? "R9" : "R8", $sformatf("vector %0d limit", i),
               lim, int'(VEC[i][7:0]));
      end

      // R5: minimum count wins, ties to lowest index
      set_acc(10, 10);
      push(0, 100, r); push(1, 101, r); push(2, 102, r); push(3, 103, r);
      alloc(0, 3); alloc(1, 1); alloc(2, 1); alloc(3, 2);
      check("R5", "offer bank", iss_bank, 1);
      @(negedge clk);
      check("R6", "held offer bank", iss_bank, 1);
      check("R6", "held offer addr", iss_addr, 101);
      pop_expect("R5", 1, 101);
      pop_expect("R5", 2, 102);
      pop_expect("R5", 3, 103);
      pop_expect("R5", 0, 100);
      check("R6", "drained valid", iss_valid, 0);
      release_n(0, 3); release_n(1, 1); release_n(2, 1); release_n(3, 2);

      // R1 order and R2 backpressure
      for (int i = 0; i < 4; i++) begin
         push(2, 200 + i, r);
         check("R1", "push accepted", r, 1);
      end
      push(2, 204, r);
      check("R2", "full bank ready", r, 0);
      push(1, 300, r);
      check("R2", "other bank ready", r, 1);
      pop_expect("R5", 1, 300);
      for (int i = 0; i < 4; i++) pop_expect("R1", 2, 200 + i);
      check("R2", "dropped push not issued", iss_valid, 0);

      // R4 gating at limit 1
      set_acc(10, 1);
      push(0, 400, r); push(1, 401, r);
      alloc(0, 2); alloc(1, 1);
      pop_expect("R4", 1, 401);
      check("R4", "over-limit bank held", iss_valid, 0);
      release_n(0, 1);
      pop_expect("R4", 0, 400);

      // R3 simultaneous events; bank0 count is 1
      push(0, 500, r);
      both(0);
      check("R3", "both at 1 keeps eligible", iss_valid, 1);
      alloc(0, 1);
      check("R3", "alloc makes ineligible", iss_valid, 0);
      both(0);
      check("R3", "both at 2 keeps ineligible", iss_valid, 0);
      release_n(0, 1);
      pop_expect("R3", 0, 500);
      release_n(0, 1); release_n(1, 1);

      // R7 full MSHR pool
      push(1, 600, r);
      alloc(3, 31);
      check("R7", "one entry left", iss_valid, 1);
      alloc(3, 1);
      check("R7", "pool full", iss_valid, 0);
      release_n(3, 1);
      pop_expect("R7", 1, 600);
      release_n(3, 31);

      done = 1;
      summary();
      $finish;
   end

endmodule